// File: doc/BRIEF.md
# Eviction-Capturing Peer Cache

This block is a second caching agent on a snooping bus, next to a processor. It builds its content only from the lines the processor writes back when it evicts them, and it keeps both the tag and the 32-byte line in a direct-mapped store. When the processor later asks for a full line that the block holds, the block claims the snoop with a modified-hit response. It then supplies the line itself as a cache-to-cache transfer, so memory does not answer.

The bus is a simplified one. A request carries an address and a two-bit kind. The block reports its snoop result one cycle after the request. Write-back data arrives as four valid-qualified 64-bit beats. These beats have no back-pressure: while the block is filling, it takes one beat on every cycle that the valid signal is high. Outgoing data is held back until the target signals ready. After that the four beats follow with no gaps, each marked by a data-ready strobe, and a busy flag covers the whole transfer. The bus issues one transaction at a time and waits for the previous one to finish before it issues the next.

Three event counters run continuously: cache-to-cache transfers, invalidation transactions, and full-line reads. A one-cycle snapshot pulse copies them to outputs and restarts them. Software can then form per-interval rates, and the hit rate is transfers divided by full-line reads.

Top module: `peer_evict_cache`

## Requirements
- R1: A request of kind 1 (eviction write-back) is followed by four beats on `wb_vld`/`wb_data`, beat 0 first. After the fourth beat the line is held, with its tag and data, at the set given by its address.
- R2: In the cycle after each accepted request, `snp_vld` is high for one cycle. `snp_hitm` is high in that cycle only for a request of kind 0 (full-line read) whose set holds a valid line with a matching tag.
- R3: The cache is direct-mapped. The set is `req_addr[IDXW+4:5]` and the tag is the bits above the set. A new eviction into a set replaces the old line, so a later read of the old line misses.
- R4: A hit sends the four beats of the line in order, beat 0 first, on four consecutive cycles. `dat_rdy` is high on each beat and `dat_busy` is held high from the first beat to the last.
- R5: The first data beat appears in the cycle after `tgt_rdy` is sampled high. While a hit waits for `tgt_rdy`, `dat_busy` stays low.
- R6: A request of kind 3 (invalidate) or kind 2 (write) to a held line removes that line, and a later read of it misses.
- R7: A read that misses gives no `snp_hitm`. `dat_busy` and `dat_rdy` stay low and `dat_out` stays zero.
- R8: A `stat_snap` pulse copies three counts to `c2c_cnt`, `inv_cnt` and `rdline_cnt`: cache-to-cache transfers, kind 3 requests, and kind 0 requests seen since the previous pulse. The live counts restart from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_vld | input | 1 | Request strobe |
| req_kind | input | 2 | 0 read line, 1 eviction, 2 write, 3 invalidate |
| req_addr | input | AW | Byte address of the request |
| wb_vld | input | 1 | Write-back beat valid |
| wb_data | input | 64 | Write-back beat data |
| tgt_rdy | input | 1 | Target ready to accept transfer data |
| snp_vld | output | 1 | Snoop result valid |
| snp_hitm | output | 1 | Modified-hit claim |
| dat_rdy | output | 1 | Outgoing beat valid |
| dat_busy | output | 1 | Transfer in progress |
| dat_out | output | 64 | Outgoing beat data |
| stat_snap | input | 1 | Latch counters and restart them |
| c2c_cnt | output | CW | Latched transfer count |
| inv_cnt | output | CW | Latched invalidation count |
| rdline_cnt | output | CW | Latched full-line read count |

## Verification
A wrong valid bit or tag shows up in the cycle right after the next request to that set. It appears as a missing or spurious `snp_hitm`, and for a spurious hit also as an unexpected data transfer. A fault in the data store only shows when the line is read back, as a wrong beat value or a beat in the wrong order. Counter faults stay hidden until the next snapshot pulse.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic [1:0] {
    K_RDLINE = 2'd0,
    K_EVICT  = 2'd1,
    K_WRITE  = 2'd2,
    K_INVAL  = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FILL,
    S_WAIT,
    S_XFER
  } ctl_st_e;
endpackage

// File: rtl/pec_store.sv
module pec_store #(
  parameter int IDXW  = 5,
  parameter int TAGW  = 22,
  parameter int DW    = 64,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDXW-1:0]          lk_idx,
  input  logic [TAGW-1:0]          lk_tag,
  output logic                     lk_hit,
  input  logic                     kill,
  input  logic                     wr_en,
  input  logic [IDXW-1:0]          wr_idx,
  input  logic [$clog2(BEATS)-1:0] wr_beat,
  input  logic [DW-1:0]            wr_data,
  input  logic                     commit,
  input  logic [TAGW-1:0]          cm_tag,
  input  logic [IDXW-1:0]          rd_idx,
  input  logic [$clog2(BEATS)-1:0] rd_beat,
  output logic [DW-1:0]            rd_data
);
  localparam int SETS = 1 << IDXW;
  localparam int BW   = $clog2(BEATS);

  logic [SETS-1:0] vld_q;
  logic [TAGW-1:0] tag_q [SETS];
  logic [DW-1:0]   dat_q [SETS*BEATS];

  assign lk_hit  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign rd_data = dat_q[{rd_idx, rd_beat}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (commit) begin
      vld_q[wr_idx] <= 1'b1;
    end else if (kill) begin
      vld_q[lk_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (commit) tag_q[wr_idx] <= cm_tag;
    if (wr_en) dat_q[{wr_idx, wr_beat}] <= wr_data;
  end

  AST_COMMIT_HOLDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> vld_q[$past(wr_idx)]); // R1
  AST_KILL_DROPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !commit) |=> !vld_q[$past(lk_idx)]); // R6

  logic [BW-1:0] unused_bw;
  assign unused_bw = wr_beat;
endmodule

// File: rtl/pec_ctrl.sv
module pec_ctrl
  import pec_pkg::*;
#(
  parameter int IDXW  = 5,
  parameter int TAGW  = 22,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_vld,
  input  logic [1:0]               req_kind,
  input  logic [IDXW-1:0]          req_idx,
  input  logic [TAGW-1:0]          req_tag,
  input  logic                     lk_hit,
  input  logic                     beat_vld,
  input  logic                     trdy,
  output logic                     kill,
  output logic                     wr_en,
  output logic [IDXW-1:0]          wr_idx,
  output logic [$clog2(BEATS)-1:0] wr_beat,
  output logic                     commit,
  output logic [TAGW-1:0]          cm_tag,
  output logic [IDXW-1:0]          rd_idx,
  output logic [$clog2(BEATS)-1:0] rd_beat,
  output logic                     snp_vld,
  output logic                     snp_hitm,
  output logic                     drdy,
  output logic                     dbsy,
  output logic                     ev_rd,
  output logic                     ev_c2c,
  output logic                     ev_inv
);
  localparam int BW = $clog2(BEATS);
  localparam logic [BW-1:0] LAST = BW'(BEATS - 1);

  ctl_st_e         st;
  bus_kind_e       kind;
  logic [IDXW-1:0] cur_idx;
  logic [TAGW-1:0] cur_tag;
  logic [BW-1:0]   beat;
  logic            take;

  assign kind   = bus_kind_e'(req_kind);
  assign take   = (st == S_IDLE) && req_vld;
  assign ev_rd  = take && (kind == K_RDLINE);
  assign ev_c2c = ev_rd && lk_hit;
  assign ev_inv = take && (kind == K_INVAL);
  assign kill   = take && lk_hit && ((kind == K_INVAL) || (kind == K_WRITE));

  assign wr_en   = (st == S_FILL) && beat_vld;
  assign wr_idx  = cur_idx;
  assign wr_beat = beat;
  assign commit  = wr_en && (beat == LAST);
  assign cm_tag  = cur_tag;
  assign rd_idx  = cur_idx;
  assign rd_beat = beat;
  assign drdy    = (st == S_XFER);
  assign dbsy    = (st == S_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_idx  <= '0;
      cur_tag  <= '0;
      beat     <= '0;
      snp_vld  <= 1'b0;
      snp_hitm <= 1'b0;
    end else begin
      snp_vld  <= 1'b0;
      snp_hitm <= 1'b0;
      unique case (st)
        S_IDLE: if (req_vld) begin
          cur_idx  <= req_idx;
          cur_tag  <= req_tag;
          beat     <= '0;
          snp_vld  <= 1'b1;
          snp_hitm <= ev_c2c;
          if (kind == K_EVICT) st <= S_FILL;
          else if (ev_c2c)     st <= S_WAIT;
        end
        S_FILL: if (beat_vld) begin
          beat <= beat + 1'b1;
          if (beat == LAST) st <= S_IDLE;
        end
        S_WAIT: if (trdy) begin
          beat <= '0;
          st   <= S_XFER;
        end
        S_XFER: begin
          beat <= beat + 1'b1;
          if (beat == LAST) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_HITM_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hitm |-> $past(req_vld && (req_kind == 2'd0))); // R2
  AST_XFER_AFTER_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbsy) |-> $past(trdy)); // R5
  AST_XFER_FULL_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dbsy) |-> ($past(rd_beat) == LAST)); // R4
endmodule

// File: rtl/pec_stats.sv
module pec_stats #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_c2c,
  input  logic          ev_inv,
  input  logic          ev_rd,
  input  logic          snap,
  output logic [CW-1:0] c2c_cnt,
  output logic [CW-1:0] inv_cnt,
  output logic [CW-1:0] rd_cnt
);
  logic [CW-1:0] c2c_live, inv_live, rd_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2c_live <= '0; inv_live <= '0; rd_live <= '0;
      c2c_cnt  <= '0; inv_cnt  <= '0; rd_cnt  <= '0;
    end else if (snap) begin
      c2c_cnt  <= c2c_live;
      inv_cnt  <= inv_live;
      rd_cnt   <= rd_live;
      c2c_live <= CW'(ev_c2c);
      inv_live <= CW'(ev_inv);
      rd_live  <= CW'(ev_rd);
    end else begin
      c2c_live <= c2c_live + CW'(ev_c2c);
      inv_live <= inv_live + CW'(ev_inv);
      rd_live  <= rd_live + CW'(ev_rd);
    end
  end

  AST_SNAP_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (c2c_live <= CW'(1)) && (inv_live <= CW'(1)) && (rd_live <= CW'(1))); // R8
  AST_C2C_WITHIN_READS: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (c2c_cnt <= rd_cnt)); // R8
endmodule

// File: rtl/peer_evict_cache.sv
module peer_evict_cache #(
  parameter int AW        = 32,
  parameter int CAP_BYTES = 1024,
  parameter int CW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_vld,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic          wb_vld,
  input  logic [63:0]   wb_data,
  input  logic          tgt_rdy,
  output logic          snp_vld,
  output logic          snp_hitm,
  output logic          dat_rdy,
  output logic          dat_busy,
  output logic [63:0]   dat_out,
  input  logic          stat_snap,
  output logic [CW-1:0] c2c_cnt,
  output logic [CW-1:0] inv_cnt,
  output logic [CW-1:0] rdline_cnt
);
  localparam int DW         = 64;
  localparam int LINE_BYTES = 32;
  localparam int BEATS      = LINE_BYTES / (DW / 8);
  localparam int BW         = $clog2(BEATS);
  localparam int OFFW       = $clog2(LINE_BYTES);
  localparam int SETS       = CAP_BYTES / LINE_BYTES;
  localparam int IDXW       = $clog2(SETS);
  localparam int TAGW       = AW - IDXW - OFFW;

  logic [IDXW-1:0] req_idx, wr_idx, rd_idx;
  logic [TAGW-1:0] req_tag, cm_tag;
  logic [BW-1:0]   wr_beat, rd_beat;
  logic [DW-1:0]   rd_data;
  logic            lk_hit, kill, wr_en, commit, ev_rd, ev_c2c, ev_inv;
  logic [OFFW-1:0] unused_off;

  assign req_idx    = req_addr[OFFW +: IDXW];
  assign req_tag    = req_addr[AW-1 -: TAGW];
  assign unused_off = req_addr[OFFW-1:0];

  pec_store #(.IDXW(IDXW), .TAGW(TAGW), .DW(DW), .BEATS(BEATS)) i_store (
    .clk, .rst_n, .lk_idx(req_idx), .lk_tag(req_tag), .lk_hit, .kill,
    .wr_en, .wr_idx, .wr_beat, .wr_data(wb_data), .commit, .cm_tag,
    .rd_idx, .rd_beat, .rd_data
  );

  pec_ctrl #(.IDXW(IDXW), .TAGW(TAGW), .BEATS(BEATS)) i_ctrl (
    .clk, .rst_n, .req_vld, .req_kind, .req_idx, .req_tag, .lk_hit,
    .beat_vld(wb_vld), .trdy(tgt_rdy), .kill, .wr_en, .wr_idx, .wr_beat,
    .commit, .cm_tag, .rd_idx, .rd_beat, .snp_vld, .snp_hitm,
    .drdy(dat_rdy), .dbsy(dat_busy), .ev_rd, .ev_c2c, .ev_inv
  );

  pec_stats #(.CW(CW)) i_stats (
    .clk, .rst_n, .ev_c2c, .ev_inv, .ev_rd, .snap(stat_snap),
    .c2c_cnt, .inv_cnt, .rd_cnt(rdline_cnt)
  );

  assign dat_out = dat_busy ? rd_data : '0;

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_busy |-> (dat_out == '0) && !dat_rdy); // R7
endmodule

// File: tb/test_peer_evict_cache.sv
module test_peer_evict_cache;
  localparam int CLK_PERIOD = 10;
  localparam int SETS = 32;

  logic clk = 0, rst_n = 0;
  logic req_vld = 0, wb_vld = 0, tgt_rdy = 0, stat_snap = 0;
  logic [1:0] req_kind = 0;
  logic [31:0] req_addr = 0;
  logic [63:0] wb_data = 0;
  logic snp_vld, snp_hitm, dat_rdy, dat_busy;
  logic [63:0] dat_out;
  logic [15:0] c2c_cnt, inv_cnt, rdline_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_evict_cache i_peer_evict_cache (
    .clk, .rst_n, .req_vld, .req_kind, .req_addr, .wb_vld, .wb_data, .tgt_rdy,
    .snp_vld, .snp_hitm, .dat_rdy, .dat_busy, .dat_out, .stat_snap,
    .c2c_cnt, .inv_cnt, .rdline_cnt
  );

  int n_chk = 0, n_fail = 0;
  bit m_vld [SETS];
  logic [21:0] m_tag [SETS];
  logic [63:0] m_dat [SETS][4];
  int m_c2c = 0, m_inv = 0, m_rd = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int tg, input int idx);
    return {22'(tg), 5'(idx), 5'($urandom % 32)};
  endfunction

  function automatic bit exp_hit(input logic [31:0] a);
    return m_vld[a[9:5]] && (m_tag[a[9:5]] == a[31:10]);
  endfunction

  task automatic issue(input logic [1:0] kind, input logic [31:0] a);
    int idx = int'(a[9:5]);
    bit hit = exp_hit(a);
    bit ehm = (kind == 2'd0) && hit;
    @(negedge clk);
    req_vld = 1; req_kind = kind; req_addr = a;
    @(negedge clk);
    req_vld = 0;
    chk(snp_vld == 1, "R2 snoop valid", 64'(snp_vld), 1);
    chk(snp_hitm == ehm, "R2/R3/R6 snoop hitm", 64'(snp_hitm), 64'(ehm));
    if (kind == 2'd0) begin m_rd++; if (hit) m_c2c++; end
    if (kind == 2'd3) m_inv++;
    if ((kind == 2'd2 || kind == 2'd3) && hit) m_vld[idx] = 0;
    if (kind == 2'd1) begin
      for (int b = 0; b < 4; b++) begin
        logic [63:0] d = {$urandom, $urandom};
        wb_vld = 1; wb_data = d; m_dat[idx][b] = d;
        @(negedge clk);
      end
      wb_vld = 0;
      m_vld[idx] = 1; m_tag[idx] = a[31:10];
    end else if (ehm) begin
      int k = $urandom % 4;
      for (int w = 0; w < k; w++) begin
        chk(dat_busy == 0, "R5 no data before target ready", 64'(dat_busy), 0);
        @(negedge clk);
      end
      tgt_rdy = 1;
      @(negedge clk);
      tgt_rdy = 0;
      for (int b = 0; b < 4; b++) begin
        chk(dat_busy && dat_rdy, "R4 busy and ready on beat", {dat_busy, dat_rdy}, 3);
        chk(dat_out == m_dat[idx][b], "R4 beat data", dat_out, m_dat[idx][b]);
        @(negedge clk);
      end
      chk(dat_busy == 0, "R4 busy ends after four beats", 64'(dat_busy), 0);
    end else begin
      chk(!dat_busy && !dat_rdy && dat_out == 0, "R7 bus quiet on miss", dat_out, 0);
      @(negedge clk);
      chk(!dat_busy && !dat_rdy && dat_out == 0, "R7 bus quiet after miss", dat_out, 0);
    end
  endtask

  task automatic snap_chk;
    @(negedge clk); stat_snap = 1;
    @(negedge clk); stat_snap = 0;
    chk(c2c_cnt == 16'(m_c2c), "R8 transfer count", c2c_cnt, m_c2c);
    chk(inv_cnt == 16'(m_inv), "R8 invalidation count", inv_cnt, m_inv);
    chk(rdline_cnt == 16'(m_rd), "R8 read count", rdline_cnt, m_rd);
    m_c2c = 0; m_inv = 0; m_rd = 0;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++) begin m_vld[s] = 0; m_tag[s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!snp_vld && !snp_hitm && !dat_busy && dat_out == 0, "reset outputs idle", dat_out, 0);
    chk(c2c_cnt == 0 && inv_cnt == 0 && rdline_cnt == 0, "R8 reset counts", c2c_cnt, 0);
    // directed
    issue(2'd0, mk_addr(5, 7));   // R7 cold miss
    issue(2'd1, mk_addr(5, 7));   // R1 fill
    issue(2'd0, mk_addr(5, 7));   // R1 hit, R4 data
    issue(2'd1, mk_addr(6, 7));   // R3 conflict replaces
    issue(2'd0, mk_addr(5, 7));   // R3 old line misses
    issue(2'd0, mk_addr(6, 7));   // R3 new line hits
    issue(2'd3, mk_addr(6, 7));   // R6 invalidate
    issue(2'd0, mk_addr(6, 7));   // R6 now misses
    issue(2'd1, mk_addr(1, 31));
    issue(2'd2, mk_addr(1, 31));  // R6 write removes
    issue(2'd0, mk_addr(1, 31));
    snap_chk();
    snap_chk();                   // R8 restart gives zeros
    // random
    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 100;
      logic [1:0] kd = (r < 35) ? 2'd1 : (r < 75) ? 2'd0 : (r < 85) ? 2'd2 : 2'd3;
      issue(kd, mk_addr($urandom % 3, $urandom % 4));
      if (i % 100 == 99) snap_chk();
    end
    snap_chk();
    finish_run();
  end
endmodule